// File: doc/BRIEF.md
# IOMMU Queue Control Register File

This block is the software-visible control register set for an I/O memory management unit. It holds the settings for three memory-resident rings: a command ring, a fault ring and a page-request ring. Each ring has a base register with a page number and a log2-size code, a software-owned index (the producer index of the command ring, the consumer index of the other two), and a control word. The block also holds a fixed capability word, a vector-routing register whose fields keep only the bits needed to name an implemented vector, a device-directory mode register and an interrupt-pending register.

Software turns a ring on by setting its enable bit and then polling until the active bit reads 1. The block models this as a timed handshake. The busy bit rises on the enable write. After `ON_DELAY` cycles, active follows enable and busy drops. Turning a ring off goes through the same steps. Accesses are single-beat reads and writes on a 64-bit data path, with one 8-byte slot per register. Read data comes back one cycle after the request. The `ring_on` outputs give the active bit of each ring to the logic that fetches from and posts to the rings.

Top module: `iomq_regfile`

## Requirements
- R1: After reset, every ring control word reads 0 (enable bit 0, interrupt-enable bit 1, active bit 16, busy bit 17). The interrupt-pending word (slot 3) reads 0. The device-directory word (slot 1) reads mode 0 (off) in bits [3:0] and busy clear in bit 4.
- R2: The capability word (slot 0) always reads 0x10 in bits [7:0], and writes to it have no effect.
- R3: The vector-routing word (slot 2) has four 4-bit fields: command [3:0], fault [7:4], performance [11:8] and page-request [15:12]. Only the low log2(NVEC) bits of each field store data. With NVEC=4, writing 0xFFFF reads back 0x3333.
- R4: A write that changes enable from 0 to 1 sets busy in the same edge. Active stays 0 for exactly `ON_DELAY` edges, then active becomes 1 and busy clears. Active never changes at the edge of the enable write.
- R5: A write that clears enable on an active ring goes through the same sequence: busy for `ON_DELAY` edges, then active 0 and busy 0.
- R6: Written values of the active and busy bits are ignored. Enable writes that arrive while busy is set are ignored.
- R7: The ring index can be written only while the ring's enable, active and busy bits are all 0. The stored value is the written value masked to log2size+1 bits. A log2size code of k-1 means 2^k entries; command and page-request entries are 16 bytes and fault entries are 32 bytes.
- R8: A write to a ring's base register while that ring is active or busy is ignored. The base layout is log2size code [4:0] and page number [53:10].
- R9: Ring n (0 command, 1 fault, 2 page-request) uses slots 4+3n (base), 5+3n (index) and 6+3n (control); the slot number is address bits [6:3]. Read data is valid exactly one cycle after a read request. Slots 13 to 15 read as 0.
- R10: `ring_on[n]` equals the active bit that ring n's control word reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 7 | Byte address; bits [6:3] select the slot |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| ring_on | output | 3 | Active state of each ring (command, fault, page-request) |

## Verification
The bench times the enable handshake edge by edge. A design that raises active at the enable write, or one edge early or late, fails the per-cycle `ring_on` check. It writes ones to the active and busy positions of an idle ring; a design that stores them would report a ring on that was never enabled. It tries index and base writes after enable and again after disable. A design without the lock would change the ring geometry under the hardware that is using it. A design without the index mask would keep index bits beyond the ring size. The all-ones write to the vector-routing word catches a design that stores the upper, unimplemented field bits.

// File: rtl/iomq_pkg.sv
package iomq_pkg;
  localparam int SLOT_W = 4;

  localparam logic [SLOT_W-1:0] SLOT_CAP   = 4'd0;
  localparam logic [SLOT_W-1:0] SLOT_DIR   = 4'd1;
  localparam logic [SLOT_W-1:0] SLOT_VEC   = 4'd2;
  localparam logic [SLOT_W-1:0] SLOT_PEND  = 4'd3;
  localparam logic [SLOT_W-1:0] SLOT_RING0 = 4'd4;

  localparam int NUM_RINGS = 3;
  localparam int RING_SLOTS = 3;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_IE_BIT   = 1;
  localparam int CTL_ON_BIT   = 16;
  localparam int CTL_BUSY_BIT = 17;

  localparam int BASE_PPN_LSB = 10;
  localparam logic [7:0] CAP_VERSION = 8'h10;

  typedef enum logic [3:0] {
    DIR_OFF  = 4'd0,
    DIR_BARE = 4'd1
  } dir_mode_e;
endpackage

// File: rtl/iomq_vec_warl.sv
module iomq_vec_warl #(
  parameter int NVEC    = 4,
  parameter int FIELDS  = 4,
  parameter int FIELD_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic [FIELDS*FIELD_W-1:0] wdata,
  output logic [FIELDS*FIELD_W-1:0] rdata
);
  localparam int KEEP = (NVEC > 1) ? $clog2(NVEC) : 1;

  for (genvar f = 0; f < FIELDS; f++) begin : g_field
    logic [KEEP-1:0] val;
    always_ff @(posedge clk) begin
      if (rst)     val <= '0;
      else if (wr) val <= wdata[f*FIELD_W +: KEEP];
    end
    if (KEEP < FIELD_W) begin : g_pad
      assign rdata[f*FIELD_W +: FIELD_W] = {{(FIELD_W-KEEP){1'b0}}, val};
    end else begin : g_full
      assign rdata[f*FIELD_W +: FIELD_W] = val[FIELD_W-1:0];
    end
  end
endmodule

// File: rtl/iomq_ring_ctl.sv
module iomq_ring_ctl
  import iomq_pkg::*;
#(
  parameter int ON_DELAY = 4,
  parameter int IDX_W    = 16,
  parameter int PPN_W    = 44,
  parameter int LOG2_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_base,
  input  logic             wr_idx,
  input  logic             wr_ctl,
  input  logic [63:0]      wdata,
  output logic [63:0]      base_rd,
  output logic [63:0]      idx_rd,
  output logic [63:0]      ctl_rd,
  output logic             on
);
  localparam int CNT_W = (ON_DELAY > 1) ? $clog2(ON_DELAY) : 1;

  logic [PPN_W-1:0]  ppn;
  logic [LOG2_W-1:0] lsz;
  logic [IDX_W-1:0]  idx;
  logic              en, ie, active, busy;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx_mask;
  logic [LOG2_W:0]   kbits;

  always_comb begin
    kbits = {1'b0, lsz} + 1'b1;
    if (int'(kbits) >= IDX_W) idx_mask = '1;
    else                      idx_mask = IDX_W'((1 << kbits) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ppn <= '0; lsz <= '0; idx <= '0;
      en <= 1'b0; ie <= 1'b0; active <= 1'b0; busy <= 1'b0; cnt <= '0;
    end else begin
      if (wr_base && !active && !busy) begin
        ppn <= wdata[BASE_PPN_LSB +: PPN_W];
        lsz <= wdata[LOG2_W-1:0];
      end
      if (wr_idx && !en && !active && !busy)
        idx <= wdata[IDX_W-1:0] & idx_mask;
      if (wr_ctl) ie <= wdata[CTL_IE_BIT];
      if (busy) begin
        if (cnt == '0) begin
          busy   <= 1'b0;
          active <= en;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (wr_ctl && (wdata[CTL_EN_BIT] != en)) begin
        en   <= wdata[CTL_EN_BIT];
        busy <= 1'b1;
        cnt  <= CNT_W'(ON_DELAY - 1);
      end
    end
  end

  always_comb begin
    base_rd = '0;
    base_rd[LOG2_W-1:0] = lsz;
    base_rd[BASE_PPN_LSB +: PPN_W] = ppn;
    idx_rd = '0;
    idx_rd[IDX_W-1:0] = idx;
    ctl_rd = '0;
    ctl_rd[CTL_EN_BIT]   = en;
    ctl_rd[CTL_IE_BIT]   = ie;
    ctl_rd[CTL_ON_BIT]   = active;
    ctl_rd[CTL_BUSY_BIT] = busy;
  end

  assign on = active;
endmodule

// File: rtl/iomq_regfile.sv
module iomq_regfile
  import iomq_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int NVEC     = 4,
  parameter int ON_DELAY = 4,
  parameter int IDX_W    = 16,
  parameter int PPN_W    = 44,
  parameter int LOG2_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic [2:0]        ring_on
);
  localparam int VEC_FIELDS = 4;
  localparam int VEC_FW     = 4;

  logic [SLOT_W-1:0] slot;
  logic              wr, rd;
  assign slot = req_addr[ADDR_W-1:3];
  assign wr   = req_valid && req_write;
  assign rd   = req_valid && !req_write;

  logic [3:0] dir_mode;
  always_ff @(posedge clk) begin
    if (rst)                          dir_mode <= DIR_OFF;
    else if (wr && slot == SLOT_DIR)  dir_mode <= req_wdata[3:0];
  end

  logic [VEC_FIELDS*VEC_FW-1:0] vec_rd;
  iomq_vec_warl #(.NVEC(NVEC), .FIELDS(VEC_FIELDS), .FIELD_W(VEC_FW)) u_vec (
    .clk(clk), .rst(rst),
    .wr(wr && slot == SLOT_VEC),
    .wdata(req_wdata[VEC_FIELDS*VEC_FW-1:0]),
    .rdata(vec_rd)
  );

  logic [63:0] base_rd [NUM_RINGS];
  logic [63:0] idx_rd  [NUM_RINGS];
  logic [63:0] ctl_rd  [NUM_RINGS];

  for (genvar n = 0; n < NUM_RINGS; n++) begin : g_ring
    localparam logic [SLOT_W-1:0] S_BASE = SLOT_W'(int'(SLOT_RING0) + RING_SLOTS*n);
    localparam logic [SLOT_W-1:0] S_IDX  = SLOT_W'(int'(S_BASE) + 1);
    localparam logic [SLOT_W-1:0] S_CTL  = SLOT_W'(int'(S_BASE) + 2);
    iomq_ring_ctl #(.ON_DELAY(ON_DELAY), .IDX_W(IDX_W), .PPN_W(PPN_W), .LOG2_W(LOG2_W)) u_ring (
      .clk(clk), .rst(rst),
      .wr_base(wr && slot == S_BASE),
      .wr_idx(wr && slot == S_IDX),
      .wr_ctl(wr && slot == S_CTL),
      .wdata(req_wdata),
      .base_rd(base_rd[n]),
      .idx_rd(idx_rd[n]),
      .ctl_rd(ctl_rd[n]),
      .on(ring_on[n])
    );
  end

  logic [63:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (slot)
      SLOT_CAP:  rd_mux[7:0] = CAP_VERSION;
      SLOT_DIR:  rd_mux[3:0] = dir_mode;
      SLOT_VEC:  rd_mux[VEC_FIELDS*VEC_FW-1:0] = vec_rd;
      SLOT_PEND: rd_mux = '0;
      default: begin
        for (int n = 0; n < NUM_RINGS; n++) begin
          if (int'(slot) == int'(SLOT_RING0) + RING_SLOTS*n)     rd_mux = base_rd[n];
          if (int'(slot) == int'(SLOT_RING0) + RING_SLOTS*n + 1) rd_mux = idx_rd[n];
          if (int'(slot) == int'(SLOT_RING0) + RING_SLOTS*n + 2) rd_mux = ctl_rd[n];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/iomq_regfile_chk.sv
module iomq_regfile_chk #(
  parameter int ADDR_W = 7,
  parameter int NVEC   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [63:0]       req_wdata,
  input logic              rsp_valid,
  input logic [63:0]       rsp_rdata,
  input logic [2:0]        ring_on
);
  localparam int KEEP = (NVEC > 1) ? $clog2(NVEC) : 1;

  function automatic logic [15:0] dead_bits();
    logic [15:0] m;
    m = '0;
    for (int f = 0; f < 4; f++)
      for (int b = KEEP; b < 4; b++) m[f*4 + b] = 1'b1;
    return m;
  endfunction
  localparam logic [15:0] DEAD = dead_bits();

  logic rd;
  logic [3:0] slot;
  assign rd   = req_valid && !req_write;
  assign slot = req_addr[ADDR_W-1:3];

  // R9
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> rsp_valid);
  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rsp_valid);
  // R2
  cap_version_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && slot == 4'd0) |=> rsp_rdata[7:0] == 8'h10);
  // R1
  pend_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && slot == 4'd3) |=> rsp_rdata == 64'd0);
  // R3
  vec_warl_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && slot == 4'd2) |=> (rsp_rdata[15:0] & DEAD) == 16'd0);

  for (genvar n = 0; n < 3; n++) begin : g_ring
    // R4
    no_instant_on_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_write && slot == 4'(6 + 3*n)) |=> $stable(ring_on[n]));
    // R10
    on_matches_ctl_chk: assert property (@(posedge clk) disable iff (rst)
      (rd && slot == 4'(6 + 3*n)) |=> rsp_rdata[16] == $past(ring_on[n]));
  end
endmodule

bind iomq_regfile iomq_regfile_chk #(.ADDR_W(ADDR_W), .NVEC(NVEC)) u_chk (.*);

// File: tb/iomq_regfile_bench.sv
module iomq_regfile_bench;
  localparam int DLY = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic [2:0]  ring_on;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  iomq_regfile #(.ON_DELAY(DLY)) u_iomq_regfile (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ring_on(ring_on)
  );

  function automatic logic [6:0] a_base(int n); return 7'((4 + 3*n) * 8); endfunction
  function automatic logic [6:0] a_idx(int n);  return 7'((5 + 3*n) * 8); endfunction
  function automatic logic [6:0] a_ctl(int n);  return 7'((6 + 3*n) * 8); endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [63:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rdreg(logic [6:0] a, output logic [63:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 valid", {63'd0, rsp_valid}, 64'd1);
    d = rsp_rdata;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    for (int n = 0; n < 3; n++) begin
      rdreg(a_ctl(n), d);
      check("R1 ctl", d, 64'd0);
    end
    rdreg(7'd24, d); check("R1 pend", d, 64'd0);
    rdreg(7'd8, d);  check("R1 dir", d & 64'h1F, 64'd0);
    check("R1 ring_on", {61'd0, ring_on}, 64'd0);
  endtask

  task automatic t_cap();
    logic [63:0] d;
    rdreg(7'd0, d); check("R2 cap", d[7:0], 64'h10);
    wr(7'd0, 64'hFF);
    rdreg(7'd0, d); check("R2 cap after write", d[7:0], 64'h10);
  endtask

  task automatic t_vec();
    logic [63:0] d;
    wr(7'd16, 64'hFFFF);
    rdreg(7'd16, d); check("R3 vec all ones", d, 64'h3333);
    wr(7'd16, 64'h9A5C);
    rdreg(7'd16, d); check("R3 vec pattern", d, 64'h1210);
  endtask

  task automatic t_status_ro();
    logic [63:0] d;
    wr(a_ctl(1), 64'h3_0000);
    rdreg(a_ctl(1), d); check("R6 on/busy ignored", d, 64'd0);
    check("R6 ring_on", {61'd0, ring_on}, 64'd0);
  endtask

  task automatic t_index();
    logic [63:0] d;
    wr(a_base(0), 64'h1);
    rdreg(a_idx(0), d); check("R7 idx reset", d, 64'd0);
    wr(a_idx(0), 64'hFF);
    rdreg(a_idx(0), d); check("R7 idx mask", d, 64'h3);
    wr(a_base(2), 64'h4);
    wr(a_idx(2), 64'hFF);
    rdreg(a_idx(2), d); check("R7 idx mask 5 bits", d, 64'h1F);
  endtask

  task automatic t_enable();
    logic [63:0] d;
    wr(a_ctl(0), 64'h3);
    check("R4 off at write edge", {61'd0, ring_on}, 64'd0);
    for (int k = 1; k <= DLY + 1; k++) begin
      @(negedge clk);
      check("R4 ring_on timing", {63'd0, ring_on[0]}, (k >= DLY) ? 64'd1 : 64'd0);
    end
    rdreg(a_ctl(0), d); check("R4 ctl active", d, 64'h1_0003);
    check("R10 ring_on", {61'd0, ring_on}, 64'b001);
    wr(a_ctl(2), 64'h1);
    rdreg(a_ctl(2), d); check("R4 busy during turn-on", d, 64'h2_0001);
    wait_cyc(DLY);
    rdreg(a_ctl(2), d); check("R4 ring 2 active", d, 64'h1_0001);
  endtask

  task automatic t_lock();
    logic [63:0] d;
    wr(a_base(0), 64'hABC4_0005);
    rdreg(a_base(0), d); check("R8 base locked", d, 64'h1);
    wr(a_idx(0), 64'h2);
    rdreg(a_idx(0), d); check("R7 idx locked", d, 64'h3);
  endtask

  task automatic t_disable();
    logic [63:0] d;
    wr(a_ctl(0), 64'h0);
    wr(a_base(0), 64'h7);
    rdreg(a_base(0), d); check("R8 base locked while busy", d, 64'h1);
    wr(a_ctl(0), 64'h1);
    wait_cyc(DLY);
    check("R5 ring off", {63'd0, ring_on[0]}, 64'd0);
    rdreg(a_ctl(0), d); check("R6 enable ignored while busy", d, 64'd0);
    wr(a_base(0), 64'h400 | 64'h2);
    rdreg(a_base(0), d); check("R8 base writable when off", d, 64'h402);
  endtask

  task automatic t_map();
    logic [63:0] d;
    rdreg(7'd104, d); check("R9 unmapped 13", d, 64'd0);
    rdreg(7'd120, d); check("R9 unmapped 15", d, 64'd0);
    wr(7'd8, 64'h1);
    rdreg(7'd8, d); check("R9 dir mode", d, 64'h1);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cap();
    t_vec();
    t_status_ro();
    t_index();
    t_enable();
    t_lock();
    t_disable();
    t_map();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule